// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the entry half of exception handling for a small 32-bit RISC pipeline. In one clock edge it chooses which event the core will take: a synchronous exception signalled by the core with a code, the tick-timer line, or the external interrupt line. For that event it captures a return address and a copy of the old status word. It forces the status word into supervisor mode with address translation and both interrupt sources disabled. It produces the handler address and pulses a request to flush the translation buffers.

The core presents its current program counter, status word and delay-slot flag every cycle. It raises `excValid` with a code when an instruction faults. All results are registered, so they appear one cycle after the edge that samples the request and stay there until the next entry. The core loads `newPc`, `nextSr`, `savedPc` and `savedSr` on the cycle `taken` is high. A code outside the supported range produces a one-cycle `badCode` pulse instead of an entry.

Top module: `trap_entry`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, every output is zero.
- R2: A new synchronous request whose code c satisfies 0 < c < NUM_EXC is taken. On the next cycle `taken` is high for exactly one cycle and `newPc` equals c shifted left by 8 bits.
- R3: A new synchronous request with code 0, or with a code of NUM_EXC or more, gives a one-cycle `badCode` pulse. In that case `taken` and `tlbFlush` stay low and `newPc`, `savedPc`, `savedSr` and `nextSr` keep their previous values.
- R4: On every entry `savedPc` is `curPc`, less 4 when `inDelaySlot` was high.
- R5: When the synchronous code equals SYSCALL_CODE (default 12), 4 is also added to `savedPc`, so a call in a delay slot saves `curPc` unchanged.
- R6: On every entry `savedSr` equals `curSr` as sampled at the entry edge.
- R7: On every entry `nextSr` is `curSr` with bit 0 (supervisor) set and bits 1 (tick enable), 2 (interrupt enable), 5 (data translation) and 6 (instruction translation) cleared. Bit 13 (delay-slot exception) is set when `inDelaySlot` was high and is copied otherwise. All other bits are copied.
- R8: `clrDelaySlot` is high in the entry cycle exactly when `inDelaySlot` was high at that entry.
- R9: `tlbFlush` is high for one cycle with every entry and at no other time.
- R10: The tick line is taken only when `curSr` bit 1 is set, and its vector is TICK_CODE (default 5). The external line is taken only when `curSr` bit 2 is set, and its vector is EXT_CODE (default 8). Neither line changes `savedPc` for a system call.
- R11: When both lines are pending and enabled, the tick vector is taken.
- R12: A new synchronous request has priority over both lines in the same cycle. When its code is illegal, no interrupt is taken in that cycle either.
- R13: A request is new only when `excValid` was low in the previous cycle. A request held high is taken once, and `excValid` must drop for a cycle before the next synchronous exception can be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curPc | input | PC_W | Program counter of the faulting or interrupted instruction |
| curSr | input | SR_W | Current status word |
| inDelaySlot | input | 1 | The instruction sits in a branch delay slot |
| excValid | input | 1 | Synchronous exception request |
| excCode | input | CODE_W | Synchronous exception number |
| extIrq | input | 1 | External interrupt pending |
| tickIrq | input | 1 | Tick-timer interrupt pending |
| taken | output | 1 | One-cycle entry strobe |
| newPc | output | PC_W | Handler vector address |
| savedPc | output | PC_W | Corrected return address |
| savedSr | output | SR_W | Status word before entry |
| nextSr | output | SR_W | Rewritten status word |
| tlbFlush | output | 1 | Translation-buffer flush request |
| clrDelaySlot | output | 1 | Tells the core to drop its delay-slot flag |
| badCode | output | 1 | Unhandled exception code strobe |

## Verification
A synchronous exception and a pending interrupt can arrive on the same edge. Delay-slot and system-call corrections to the return address can also both apply to one entry. The bench raises a request together with both enabled interrupt lines and checks that the request's own vector wins. It then pairs an illegal code with an enabled tick and expects only the error pulse. A system call issued in a delay slot must save the unmodified PC, which shows that the two adjustments cancel rather than one masking the other.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  // status word bit positions
  localparam int SR_SUPER = 0;
  localparam int SR_TICKEN = 1;
  localparam int SR_IRQEN = 2;
  localparam int SR_DXLAT = 5;
  localparam int SR_IXLAT = 6;
  localparam int SR_DSEXC = 13;

  // strobes from control to datapath
  typedef struct packed {
    logic take;
    logic dsAdj;
    logic callAdj;
    logic raiseErr;
  } trapCtl_t;
endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int NUM_EXC = 16,
  parameter int CODE_W = 4,
  parameter int SYSCALL_CODE = 12,
  parameter int TICK_CODE = 5,
  parameter int EXT_CODE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCode,
  input  logic              inDelaySlot,
  input  logic              extIrq,
  input  logic              tickIrq,
  input  logic              tickEn,
  input  logic              irqEn,
  output trapCtl_t          ctl,
  output logic [CODE_W-1:0] selCode
);
  localparam int CODE_SPAN = 2 ** CODE_W;

  logic excPrev;
  logic excNew;
  logic codeInRange;
  logic codeOk;
  logic tickOk;
  logic extOk;

  always_ff @(posedge clk) begin
    if (!rstN) excPrev <= 1'b0;
    else       excPrev <= excValid;
  end

  assign excNew = excValid && !excPrev;

  generate
    if (NUM_EXC >= CODE_SPAN) begin : g_fullRange
      assign codeInRange = 1'b1;
    end else begin : g_partRange
      assign codeInRange = (excCode < CODE_W'(NUM_EXC));
    end
  endgenerate

  assign codeOk = (excCode != '0) && codeInRange;
  assign tickOk = tickIrq && tickEn;
  assign extOk = extIrq && irqEn;

  always_comb begin
    ctl = '0;
    selCode = '0;
    ctl.dsAdj = inDelaySlot;
    if (excNew) begin
      if (codeOk) begin
        ctl.take = 1'b1;
        selCode = excCode;
        ctl.callAdj = (excCode == CODE_W'(SYSCALL_CODE));
      end else begin
        ctl.raiseErr = 1'b1;
      end
    end else if (tickOk) begin
      ctl.take = 1'b1;
      selCode = CODE_W'(TICK_CODE);
    end else if (extOk) begin
      ctl.take = 1'b1;
      selCode = CODE_W'(EXT_CODE);
    end
  end
endmodule

// File: rtl/trap_entry_dp.sv
module trap_entry_dp
  import trap_entry_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int SR_W = 16,
  parameter int CODE_W = 4,
  parameter int VEC_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  trapCtl_t          ctl,
  input  logic [CODE_W-1:0] selCode,
  input  logic [PC_W-1:0]   curPc,
  input  logic [SR_W-1:0]   curSr,
  output logic              taken,
  output logic [PC_W-1:0]   newPc,
  output logic [PC_W-1:0]   savedPc,
  output logic [SR_W-1:0]   savedSr,
  output logic [SR_W-1:0]   nextSr,
  output logic              tlbFlush,
  output logic              clrDelaySlot,
  output logic              badCode
);
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  logic [PC_W-1:0] retPc;
  logic [PC_W-1:0] vecPc;
  logic [SR_W-1:0] srMod;

  always_comb begin
    retPc = curPc;
    if (ctl.dsAdj) retPc = retPc - INSN_BYTES;
    if (ctl.callAdj) retPc = retPc + INSN_BYTES;
  end

  assign vecPc = PC_W'(selCode) << VEC_SHIFT;

  always_comb begin
    srMod = curSr;
    srMod[SR_DXLAT] = 1'b0;
    srMod[SR_IXLAT] = 1'b0;
    srMod[SR_IRQEN] = 1'b0;
    srMod[SR_TICKEN] = 1'b0;
    srMod[SR_SUPER] = 1'b1;
    if (ctl.dsAdj) srMod[SR_DSEXC] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      taken <= 1'b0;
      tlbFlush <= 1'b0;
      clrDelaySlot <= 1'b0;
      badCode <= 1'b0;
      newPc <= '0;
      savedPc <= '0;
      savedSr <= '0;
      nextSr <= '0;
    end else begin
      taken <= ctl.take;
      tlbFlush <= ctl.take;
      clrDelaySlot <= ctl.take && ctl.dsAdj;
      badCode <= ctl.raiseErr;
      if (ctl.take) begin
        newPc <= vecPc;
        savedPc <= retPc;
        savedSr <= curSr;
        nextSr <= srMod;
      end
    end
  end
endmodule

// File: rtl/trap_entry.sv
module trap_entry
  import trap_entry_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int SR_W = 16,
  parameter int NUM_EXC = 16,
  parameter int CODE_W = 4,
  parameter int VEC_SHIFT = 8,
  parameter int SYSCALL_CODE = 12,
  parameter int TICK_CODE = 5,
  parameter int EXT_CODE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   curPc,
  input  logic [SR_W-1:0]   curSr,
  input  logic              inDelaySlot,
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCode,
  input  logic              extIrq,
  input  logic              tickIrq,
  output logic              taken,
  output logic [PC_W-1:0]   newPc,
  output logic [PC_W-1:0]   savedPc,
  output logic [SR_W-1:0]   savedSr,
  output logic [SR_W-1:0]   nextSr,
  output logic              tlbFlush,
  output logic              clrDelaySlot,
  output logic              badCode
);
  trapCtl_t ctl;
  logic [CODE_W-1:0] selCode;

  trap_entry_ctrl #(
    .NUM_EXC(NUM_EXC), .CODE_W(CODE_W), .SYSCALL_CODE(SYSCALL_CODE),
    .TICK_CODE(TICK_CODE), .EXT_CODE(EXT_CODE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excCode(excCode),
    .inDelaySlot(inDelaySlot), .extIrq(extIrq), .tickIrq(tickIrq),
    .tickEn(curSr[SR_TICKEN]), .irqEn(curSr[SR_IRQEN]),
    .ctl(ctl), .selCode(selCode)
  );

  trap_entry_dp #(
    .PC_W(PC_W), .SR_W(SR_W), .CODE_W(CODE_W), .VEC_SHIFT(VEC_SHIFT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .selCode(selCode),
    .curPc(curPc), .curSr(curSr), .taken(taken), .newPc(newPc),
    .savedPc(savedPc), .savedSr(savedSr), .nextSr(nextSr),
    .tlbFlush(tlbFlush), .clrDelaySlot(clrDelaySlot), .badCode(badCode)
  );
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_entry_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int SR_W = 16,
  parameter int VEC_SHIFT = 8,
  parameter int TICK_CODE = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic [SR_W-1:0] curSr,
  input logic            inDelaySlot,
  input logic            excValid,
  input logic            extIrq,
  input logic            tickIrq,
  input logic            taken,
  input logic [PC_W-1:0] newPc,
  input logic [SR_W-1:0] savedSr,
  input logic [SR_W-1:0] nextSr,
  input logic            tlbFlush,
  input logic            clrDelaySlot,
  input logic            badCode
);
  localparam logic [PC_W-1:0] TICK_VEC = PC_W'(TICK_CODE) << VEC_SHIFT;

  assert_vec_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> (newPc[VEC_SHIFT-1:0] == '0) && (newPc != '0));

  assert_no_both_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(taken && badCode));

  assert_old_status_R6: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> savedSr == $past(curSr));

  assert_sr_rewrite_R7: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> nextSr[SR_SUPER] && !nextSr[SR_TICKEN] && !nextSr[SR_IRQEN]
              && !nextSr[SR_DXLAT] && !nextSr[SR_IXLAT]);

  assert_ds_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    clrDelaySlot |-> taken && $past(inDelaySlot));

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    tlbFlush |-> taken && $past(excValid || tickIrq || extIrq));

  assert_tick_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!excValid && tickIrq && extIrq && curSr[SR_TICKEN] && curSr[SR_IRQEN])
    |=> taken && (newPc == TICK_VEC));

  assert_held_once_R13: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && $past(excValid) && !tickIrq && !extIrq) |=> !taken && !badCode);
endmodule

bind trap_entry trap_entry_chk #(
  .PC_W(PC_W), .SR_W(SR_W), .VEC_SHIFT(VEC_SHIFT), .TICK_CODE(TICK_CODE)
) i_chk (
  .clk(clk), .rstN(rstN), .curSr(curSr), .inDelaySlot(inDelaySlot),
  .excValid(excValid), .extIrq(extIrq), .tickIrq(tickIrq), .taken(taken),
  .newPc(newPc), .savedSr(savedSr), .nextSr(nextSr), .tlbFlush(tlbFlush),
  .clrDelaySlot(clrDelaySlot), .badCode(badCode)
);

// File: tb/test_trap_entry.sv
module test_trap_entry;
  localparam int NUM_EXC = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] curPc = '0;
  logic [15:0] curSr = '0;
  logic inDelaySlot = 1'b0;
  logic excValid = 1'b0;
  logic [3:0] excCode = '0;
  logic extIrq = 1'b0;
  logic tickIrq = 1'b0;
  logic taken, tlbFlush, clrDelaySlot, badCode;
  logic [31:0] newPc, savedPc;
  logic [15:0] savedSr, nextSr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  trap_entry #(.NUM_EXC(NUM_EXC)) i_trap_entry (
    .clk(clk), .rstN(rstN), .curPc(curPc), .curSr(curSr),
    .inDelaySlot(inDelaySlot), .excValid(excValid), .excCode(excCode),
    .extIrq(extIrq), .tickIrq(tickIrq), .taken(taken), .newPc(newPc),
    .savedPc(savedPc), .savedSr(savedSr), .nextSr(nextSr),
    .tlbFlush(tlbFlush), .clrDelaySlot(clrDelaySlot), .badCode(badCode)
  );

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expSr(logic [15:0] sr, logic ds);
    logic [15:0] r;
    r = (sr & ~16'h0066) | 16'h0001;
    if (ds) r = r | 16'h2000;
    return r;
  endfunction

  logic [31:0] lastVec = '0, lastRet = '0;
  logic [15:0] lastEsr = '0, lastSr = '0;

  task automatic expectEntry(string req, int code, logic [31:0] pc,
                             logic [15:0] sr, logic ds, logic isCall);
    logic [31:0] ret;
    ret = pc - (ds ? 32'd4 : 32'd0) + (isCall ? 32'd4 : 32'd0);
    chk({req, " taken"}, 32'(taken), 32'd1);
    chk({req, " vector"}, newPc, 32'(code) << 8);
    chk({req, " R4/R5 return"}, savedPc, ret);
    chk({req, " R6 saved status"}, 32'(savedSr), 32'(sr));
    chk({req, " R7 new status"}, 32'(nextSr), 32'(expSr(sr, ds)));
    chk({req, " R8 delay flag"}, 32'(clrDelaySlot), 32'(ds));
    chk({req, " R9 flush"}, 32'(tlbFlush), 32'd1);
    chk({req, " R3 no error"}, 32'(badCode), 32'd0);
    lastVec = newPc; lastRet = savedPc; lastEsr = savedSr; lastSr = nextSr;
  endtask

  task automatic expectIdle(string req);
    chk({req, " taken low"}, 32'(taken), 32'd0);
    chk({req, " flush low"}, 32'(tlbFlush), 32'd0);
    chk({req, " vector kept"}, newPc, lastVec);
    chk({req, " return kept"}, savedPc, lastRet);
    chk({req, " saved status kept"}, 32'(savedSr), 32'(lastEsr));
    chk({req, " new status kept"}, 32'(nextSr), 32'(lastSr));
  endtask

  task automatic clearIn();
    excValid = 1'b0; tickIrq = 1'b0; extIrq = 1'b0; inDelaySlot = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [31:0] pc;
    logic [15:0] sr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset taken", 32'(taken), 32'd0);
    chk("R1 reset vector", newPc, 32'd0);
    chk("R1 reset status", 32'(nextSr), 32'd0);
    chk("R1 reset error", 32'(badCode), 32'd0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 first cycle idle", 32'(taken | tlbFlush | badCode | clrDelaySlot), 32'd0);

    // R2 R3 R4 R5 R6 R7 R8 R9: full sweep of codes and delay slot
    for (int code = 0; code < 16; code++) begin
      for (int ds = 0; ds < 2; ds++) begin
        pc = 32'h4000_0000 + 32'(code) * 32'h100 + 32'(ds) * 32'h10;
        sr = 16'(32'h1357 * (code + 1) + ds * 32'h0f0f);
        curPc = pc; curSr = sr; inDelaySlot = ds[0];
        excCode = 4'(code); excValid = 1'b1;
        @(posedge clk); @(negedge clk);
        if (code > 0 && code < NUM_EXC) begin
          expectEntry("R2 sync", code, pc, sr, ds[0], code == 12);
        end else begin
          chk("R3 bad code flag", 32'(badCode), 32'd1);
          expectIdle("R3 bad code");
        end
        clearIn();
        chk("R2 one-cycle taken", 32'(taken), 32'd0);
        chk("R3 one-cycle error", 32'(badCode), 32'd0);
      end
    end

    // R10 R11: every combination of lines and enables
    for (int m = 0; m < 16; m++) begin
      logic tk, ex, te, ie;
      int code;
      tk = m[0]; ex = m[1]; te = m[2]; ie = m[3];
      pc = 32'h0800_0000 + 32'(m) * 32'h40;
      sr = 16'hA198 | (te ? 16'h0002 : 16'h0) | (ie ? 16'h0004 : 16'h0);
      curPc = pc; curSr = sr; excCode = 4'd12;
      tickIrq = tk; extIrq = ex; inDelaySlot = m[1];
      @(posedge clk); @(negedge clk);
      code = (tk && te) ? 5 : ((ex && ie) ? 8 : 0);
      if (code != 0) expectEntry((tk && te && ex && ie) ? "R11 tick first" : "R10 irq", code, pc, sr, m[1], 1'b0);
      else expectIdle("R10 gated");
      clearIn();
    end

    // R12: synchronous request against enabled lines
    pc = 32'h0000_3000; sr = 16'h0007;
    curPc = pc; curSr = sr; excCode = 4'd3; excValid = 1'b1;
    tickIrq = 1'b1; extIrq = 1'b1;
    @(posedge clk); @(negedge clk);
    expectEntry("R12 sync wins", 3, pc, sr, 1'b0, 1'b0);
    clearIn();
    excCode = 4'd0; excValid = 1'b1; tickIrq = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R12 bad code blocks irq", 32'(badCode), 32'd1);
    expectIdle("R12 bad code blocks irq");
    clearIn();

    // R13: held request taken once
    pc = 32'h0000_5550; sr = 16'h0001;
    curPc = pc; curSr = sr; excCode = 4'd4; excValid = 1'b1;
    @(posedge clk); @(negedge clk);
    expectEntry("R13 first edge", 4, pc, sr, 1'b0, 1'b0);
    @(posedge clk); @(negedge clk);
    expectIdle("R13 held");
    chk("R13 held no error", 32'(badCode), 32'd0);
    @(posedge clk); @(negedge clk);
    expectIdle("R13 still held");
    clearIn();
    excValid = 1'b1; excCode = 4'd6;
    @(posedge clk); @(negedge clk);
    expectEntry("R13 after drop", 6, pc, sr, 1'b0, 1'b0);
    clearIn();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule